// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a timer of the kind that sits beside a processor core. It holds a free-running counter and a comparison register, and it raises a timer request when the counter arrives at the comparison value. Both registers can be loaded through simple write-enable/data ports and are always visible on read-data ports. The integrator supplies a tick-enable strobe at the wanted time base, for example one pulse every 10 ns for a 100 MHz rate. A freeze input stops the counter.

The request is raised on the step into equality between the counter and the comparison register. It stays up until software writes the comparison register, which is the acknowledge. A 3-bit routing input chooses which one of eight interrupt lines carries the request. A software-visible pending flag mirrors the request. A parameter can remove that flag without changing how the interrupt line behaves.

Top module: `cmp_timer_top`

## Requirements
- R1: While reset is high and in the first cycle after it, the counter, the comparison register and the pending flag read zero and all eight interrupt lines are low. The equality that exists at reset raises no request.
- R2: With tick enable high, freeze low and no counter write, the counter goes up by one at each clock edge and wraps from all-ones to zero.
- R3: With tick enable low, the counter keeps its value.
- R4: With freeze high, the counter keeps its value even when tick enable is high. No match is detected while freeze is high, including a counter write that lands on the comparison value.
- R5: A counter write loads the written value at the next edge and takes priority over a tick. Counting then continues from the loaded value.
- R6: When counting brings the counter to the comparison value, the request and the pending flag go high at the edge after the one that made them equal.
- R7: A counter write that makes the counter equal to the comparison value also raises the request one edge later.
- R8: A comparison write clears the request and the pending flag at its edge. This holds even when a match would have set them at that same edge.
- R9: Once raised, the request stays high while the counter moves on, until a comparison write or reset.
- R10: Interrupt line number N is high only when the request is high and the routing input equals N. At most one line is high at any time, and changing the routing input moves the request to the new line in the same cycle.
- R11: With the pending-flag parameter set to 0, the pending flag stays at zero while the interrupt line still asserts on a match.
- R12: The comparison read port returns the last value written to the comparison register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter by one when high |
| freeze | input | 1 | Stops counting and match detection |
| route_sel | input | SEL_W (3) | Selects the interrupt line for the request |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W (32) | Counter write value |
| cmp_we | input | 1 | Comparison write strobe, also the acknowledge |
| cmp_wdata | input | CNT_W (32) | Comparison write value |
| cnt_rdata | output | CNT_W (32) | Current counter value |
| cmp_rdata | output | CNT_W (32) | Current comparison value |
| pend | output | 1 | Timer pending flag |
| irq_out | output | LINES (8) | Interrupt lines, one-hot or zero |

## Verification
A wrong counter action appears on the counter read port at the very next edge as a skipped, repeated or wrong value. The bench therefore compares the count after every edge of every trial with an arithmetic expectation. A fault in the equality history or the request flop shows one edge after the match as a late, early, missing or doubled interrupt, because the request is registered exactly once. A routing fault shows at once as the wrong line or as more than one line high. The sweep rotates the routing value across all eight lines and brings the counter up to compare values spread over the whole range, including ones where the counter wraps.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    // What the counter register does at the next edge
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_INC  = 2'd2
    } cnt_action_e;

    // Request state kept by the match stage
    typedef struct packed {
        logic req;   // drives the routed interrupt line
        logic pend;  // software-visible flag (may be gated off)
    } tmr_status_t;

    localparam tmr_status_t STATUS_IDLE = '{req: 1'b0, pend: 1'b0};

    // Priority: a load beats a tick; freeze or no tick holds
    function automatic cnt_action_e pick_action(input logic we,
                                                input logic tick,
                                                input logic frz);
        if (we)
            return CNT_LOAD;
        else if (tick && !frz)
            return CNT_INC;
        else
            return CNT_HOLD;
    endfunction

    // Request update: acknowledge beats a new match
    function automatic tmr_status_t next_status(input tmr_status_t cur,
                                                input logic ack,
                                                input logic hit,
                                                input logic pend_on);
        tmr_status_t n;
        n = cur;
        if (ack) begin
            n = STATUS_IDLE;
        end else if (hit) begin
            n.req  = 1'b1;
            n.pend = pend_on;
        end
        return n;
    endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_action_e act;

    always_comb begin
        act = pick_action(cnt_we, tick_en, freeze);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                CNT_LOAD: cnt_q <= cnt_wdata;
                CNT_INC:  cnt_q <= cnt_q + ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Counter advances by one per tick and wraps
    assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !freeze && !cnt_we) |=> (cnt_q == CNT_W'($past(cnt_q) + ONE)));

    // No tick: value held
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_we) |=> $stable(cnt_q));

    // Freeze holds the value
    assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (freeze && !cnt_we) |=> $stable(cnt_q));

    // Load wins over tick
    assert_load_value_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_q == $past(cnt_wdata)));

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter bit PEND_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_q,
    output tmr_status_t      status
);

    logic        eq_now;
    logic        eq_prev;
    logic        hit;
    tmr_status_t status_nx;

    // Comparison register
    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= cmp_wdata;
    end

    // Edge into equality; reset value 1 because both registers reset to zero
    always_comb begin
        eq_now = (cnt_q == cmp_q);
        hit    = eq_now && !eq_prev && !freeze;
    end

    always_ff @(posedge clk) begin
        if (rst)
            eq_prev <= 1'b1;
        else
            eq_prev <= eq_now;
    end

    always_comb begin
        status_nx = next_status(status, cmp_we, hit, PEND_EN);
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= STATUS_IDLE;
        else
            status <= status_nx;
    end

    // Acknowledge clears request
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (!status.req && !status.pend));

    // Request is sticky until acknowledge
    assert_req_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (status.req && !cmp_we) |=> status.req);

    // Request only rises from a match of counter and compare
    assert_req_from_match_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status.req) |-> $past(cnt_q == cmp_q));

    // Frozen: no new request
    assert_frozen_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (freeze && !status.req) |=> !status.req);

    // Compare register follows its write
    assert_cmp_load_R12: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (cmp_q == $past(cmp_wdata)));

    generate
        if (!PEND_EN) begin : g_no_pend
            // Pending flag removed
            assert_pend_off_R11: assert property (@(posedge clk) disable iff (rst)
                !status.pend);
        end
    endgenerate

endmodule

// File: rtl/cmp_timer_route.sv
module cmp_timer_route #(
    parameter int LINES = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [SEL_W-1:0] route_sel,
    output logic [LINES-1:0] irq_out
);

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            assign irq_out[i] = req && (route_sel == SEL_W'(i));
        end
    endgenerate

    // At most one line, and none without a request
    assert_onehot_lines_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

    assert_no_idle_line_R10: assert property (@(posedge clk) disable iff (rst)
        !req |-> (irq_out == '0));

endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LINES   = 8,
    parameter int SEL_W   = $clog2(LINES),
    parameter bit PEND_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic [SEL_W-1:0] route_sel,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic [CNT_W-1:0] cmp_rdata,
    output logic             pend,
    output logic [LINES-1:0] irq_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    tmr_status_t      status;

    cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .freeze    (freeze),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .cnt_q     (cnt_q)
    );

    cmp_timer_match #(.CNT_W(CNT_W), .PEND_EN(PEND_EN)) u_match (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .cnt_q     (cnt_q),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .cmp_q     (cmp_q),
        .status    (status)
    );

    cmp_timer_route #(.LINES(LINES), .SEL_W(SEL_W)) u_route (
        .clk       (clk),
        .rst       (rst),
        .req       (status.req),
        .route_sel (route_sel),
        .irq_out   (irq_out)
    );

    assign cnt_rdata = cnt_q;
    assign cmp_rdata = cmp_q;
    assign pend      = status.pend;

    // Reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (cnt_rdata == '0 && cmp_rdata == '0 && !pend && irq_out == '0));

endmodule

// File: tb/cmp_timer_top_tb.sv
module cmp_timer_top_tb;

    localparam int W = 8;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick_en, freeze, cnt_we, cmp_we;
    logic [2:0]   route_sel;
    logic [W-1:0] cnt_wdata, cmp_wdata;
    logic [W-1:0] cnt_rdata, cmp_rdata, cnt_np, cmp_np;
    logic         pend, pend_np;
    logic [7:0]   irq_out, irq_np;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_timer_top #(.CNT_W(W), .LINES(8), .PEND_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
        .route_sel(route_sel), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_rdata(cnt_rdata),
        .cmp_rdata(cmp_rdata), .pend(pend), .irq_out(irq_out)
    );

    cmp_timer_top #(.CNT_W(W), .LINES(8), .PEND_EN(1'b0)) u_dut_np (
        .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
        .route_sel(route_sel), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_rdata(cnt_np),
        .cmp_rdata(cmp_np), .pend(pend_np), .irq_out(irq_np)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cnt(input int v);
        cnt_we = 1'b1; cnt_wdata = W'(v);
        cyc();
        cnt_we = 1'b0;
    endtask

    task automatic wr_cmp(input int v);
        cmp_we = 1'b1; cmp_wdata = W'(v);
        cyc();
        cmp_we = 1'b0;
    endtask

    function automatic int line_of(input bit on, input int r);
        return on ? (1 << r) : 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(10 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; tick_en = 1'b0; freeze = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0;
        route_sel = 3'd0; cnt_wdata = '0; cmp_wdata = '0;
        repeat (3) cyc();
        // R1 during reset
        check(cnt_rdata == 0 && cmp_rdata == 0, "R1 regs in reset", int'(cnt_rdata), 0);
        check(irq_out == 0 && !pend, "R1 outputs in reset", int'(irq_out), 0);
        rst = 1'b0;
        // R1 after reset: equality at zero raises nothing
        repeat (3) begin
            cyc();
            check(irq_out == 0 && irq_np == 0 && !pend, "R1 no request after reset", int'(irq_out), 0);
        end

        // R3 tick low holds
        wr_cnt(77);
        repeat (4) cyc();
        check(cnt_rdata == 77, "R3 hold without tick", int'(cnt_rdata), 77);

        // R2 wrap
        wr_cnt(MOD - 2);
        tick_en = 1'b1;
        cyc(); check(cnt_rdata == W'(MOD - 1), "R2 step", int'(cnt_rdata), MOD - 1);
        cyc(); check(cnt_rdata == 0, "R2 wrap to zero", int'(cnt_rdata), 0);
        cyc(); check(cnt_rdata == 1, "R2 after wrap", int'(cnt_rdata), 1);

        // R5 write beats tick, counting resumes
        cnt_we = 1'b1; cnt_wdata = 8'd100; cyc(); cnt_we = 1'b0;
        check(cnt_rdata == 100, "R5 load over tick", int'(cnt_rdata), 100);
        cyc(); check(cnt_rdata == 101, "R5 resume from load", int'(cnt_rdata), 101);
        tick_en = 1'b0;
        wr_cmp(5);   // clear anything raised on the way
        cyc();

        // Sweep: R2 R6 R9 R10 R11
        for (int m = 0; m < MOD; m += 7) begin
            for (int d = 1; d <= 5; d++) begin
                int c0;
                int r;
                c0 = (m - d + MOD) % MOD;
                r = (m + d) % 8;
                route_sel = 3'(r);
                tick_en = 1'b0;
                wr_cnt(c0);
                wr_cmp(m);
                check(irq_out == 0 && !pend, "R8 clear before trial", int'(irq_out), 0);
                check(cmp_rdata == W'(m), "R12 compare readback", int'(cmp_rdata), m);
                tick_en = 1'b1;
                for (int k = 1; k <= d + 2; k++) begin
                    bit on;
                    cyc();
                    on = (k >= d + 1);
                    check(cnt_rdata == W'(c0 + k), "R2 sweep count", int'(cnt_rdata), (c0 + k) % MOD);
                    check(irq_out == 8'(line_of(on, r)), "R6 R9 R10 line", int'(irq_out), line_of(on, r));
                    check(pend == on, "R6 pending", int'(pend), int'(on));
                    check(!pend_np && irq_np == 8'(line_of(on, r)), "R11 no pending flag", int'(pend_np), 0);
                end
                tick_en = 1'b0;
            end
        end

        // R10 route change moves request at once
        route_sel = 3'd6;
        #1 check(irq_out == 8'h40, "R10 route change", int'(irq_out), 8'h40);
        route_sel = 3'd1;
        #1 check(irq_out == 8'h02, "R10 route change back", int'(irq_out), 8'h02);

        // R9 sticky while counter runs far
        tick_en = 1'b1;
        repeat (20) cyc();
        check(irq_out == 8'h02 && pend, "R9 stays set", int'(irq_out), 8'h02);
        tick_en = 1'b0;
        // R8 ack clears at its edge
        wr_cmp(200);
        check(irq_out == 0 && !pend, "R8 compare write clears", int'(irq_out), 0);

        // R7 count write lands on compare
        wr_cmp(40);
        wr_cnt(40);
        check(irq_out == 0, "R7 not yet", int'(irq_out), 0);
        cyc();
        check(irq_out == 8'h02 && pend, "R7 write onto compare raises", int'(irq_out), 8'h02);
        wr_cmp(90);

        // R8 ack at the same edge as a match
        wr_cmp(50);
        wr_cnt(50);
        cmp_we = 1'b1; cmp_wdata = 8'd60; cyc(); cmp_we = 1'b0;
        check(irq_out == 0 && !pend, "R8 ack beats match", int'(irq_out), 0);
        cyc();
        check(irq_out == 0 && !pend, "R8 no late raise", int'(irq_out), 0);

        // R4 freeze holds and suppresses match
        wr_cnt(10);
        wr_cmp(12);
        freeze = 1'b1; tick_en = 1'b1;
        repeat (10) cyc();
        check(cnt_rdata == 10, "R4 frozen count", int'(cnt_rdata), 10);
        check(irq_out == 0, "R4 frozen no match", int'(irq_out), 0);
        wr_cnt(12);
        repeat (3) cyc();
        check(cnt_rdata == 12 && irq_out == 0 && !pend, "R4 frozen write onto compare", int'(irq_out), 0);
        freeze = 1'b0;
        cyc();
        check(cnt_rdata == 13, "R4 resume after freeze", int'(cnt_rdata), 13);
        check(irq_out == 0, "R4 no late match", int'(irq_out), 0);

        tick_en = 1'b0;
        cyc();
        finish_run();
    end

endmodule